// File: doc/BRIEF.md
# Instruction Context Propagation Unit

The unit stores seven instruction contexts. Each context has its own 40-bit schedule FIFO, and each bit in that FIFO stands for one upcoming instruction. A setup command loads a context word into a slot. In the same command it appends a run of schedule bits to that slot's FIFO, starting just after the bits already queued there.

Each time an instruction retires, the unit looks at the bottom bit of every FIFO. It ORs together the contexts whose bottom bit is set and presents the result on a registered output for one cycle. It then shifts every FIFO down by one position. If the merged contexts are of different kinds, an illegal flag is raised alongside the result.

Decoding the instruction and applying the merged context are left to the surrounding pipeline.

Top module: `ctxprop_unit`

## Requirements
- R1: After a synchronous active-low reset, the outputs are all zero: `out_valid`, `out_ctx` and `out_illegal`. All seven schedules are empty, so steps issued before any setup produce no valid output.
- R2: A setup command carries a 21-bit immediate. Let t be the bit number of the lowest set bit, numbered from bit 0. The command queues 20−t schedule bits, taken in order imm[20], imm[19], and so on. imm[20] belongs to the first instruction that uses the new bits. An immediate of zero queues nothing.
- R3: New schedule bits are placed directly after the bits already pending in the addressed slot. A second setup to the same slot therefore extends its schedule and does not overwrite it.
- R4: A `step` pulse consumes one schedule bit from every slot. The merged result appears on the outputs in the cycle after the step. Cycles without a step leave the schedules untouched and show zero outputs.
- R5: `out_ctx` is the bitwise OR of the stored contexts of every slot whose current schedule bit is 1.
- R6: The kind of a context comes from bits [31:24]. 8'h00 is RM and 8'h01 is setvl. If bits [31:28] are 1, 2 or 3, the kind is swizzle, remap or sub-vector remap respectively. Any other value is a kind of its own. `out_illegal` is 1 exactly when the active slots of a step hold contexts of two or more kinds.
- R7: A step in which no slot has its current bit set gives `out_valid` = 0 and `out_ctx` = 0.
- R8: A schedule holds at most 40 pending bits. Bits beyond that limit are dropped.
- R9: When a setup and a step occur in the same cycle, the step is taken first. It uses the slot's old context and old bits, and the new bits then queue behind what remains.
- R10: A setup command with slot index 0 changes nothing.
- R11: A setup replaces the slot's stored context for every later step, including steps that consume bits queued earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| setup_valid | input | 1 | Setup command present |
| setup_idx | input | 3 | Target slot, 1 to 7; 0 means no slot |
| setup_ctx | input | 32 | Context word to store in the slot |
| setup_imm | input | 21 | Schedule immediate, with the lowest set bit as a stop marker |
| step | input | 1 | One instruction retired |
| out_valid | output | 1 | At least one context applied to the stepped instruction |
| out_ctx | output | 32 | OR of the applied contexts |
| out_illegal | output | 1 | Applied contexts were of mixed kinds |

## Verification
The bench targets several corner cases and the failure each one would expose:
- Repeated appends to one slot. A design that resets the fill point would overwrite pending bits, so later instructions would see the wrong context.
- Setups that overflow the 40-bit limit. A design that wraps the offset would corrupt the front of the schedule.
- A setup and a step in the same cycle. A design that inserts before shifting would lose the first new bit or apply it one instruction early.
- The zero immediate, index 0, and replacing a context while old bits are still pending.
- Mixed-kind merges, including the two RM-family codes that differ only in bits [27:24]. A coarse kind decoder would miss these.

// File: rtl/ctxprop_pkg.sv
// Package: shared kind encoding and the kind decoder for stored contexts.
// Assumes the kind lives in the top byte of a 32-bit context word.
package ctxprop_pkg;

    typedef enum logic [2:0] {
        KIND_RM      = 3'd0,
        KIND_SETVL   = 3'd1,
        KIND_SWIZZLE = 3'd2,
        KIND_REMAP   = 3'd3,
        KIND_SUBREMAP= 3'd4,
        KIND_OTHER   = 3'd5
    } ctx_kind_e;

    // Decode the kind from the top byte of a context word.
    function automatic ctx_kind_e kind_of(input logic [7:0] top);
        ctx_kind_e k;
        unique case (top[7:4])
            4'h0:    k = (top[3:0] == 4'h0) ? KIND_RM :
                         (top[3:0] == 4'h1) ? KIND_SETVL : KIND_OTHER;
            4'h1:    k = KIND_SWIZZLE;
            4'h2:    k = KIND_REMAP;
            4'h3:    k = KIND_SUBREMAP;
            default: k = KIND_OTHER;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ctxprop_lane.sv
// Module: one context slot. Holds the stored context, the schedule shift
// register and the fill offset. The step shift is applied before any
// same-cycle append. Assumes the immediate's lowest set bit is a stop marker.
module ctxprop_lane
    import ctxprop_pkg::*;
#(
    parameter int SREG_W = 40,
    parameter int IMM_W  = 21,
    parameter int CTX_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             wr_i,
    input  logic [CTX_W-1:0] wr_ctx_i,
    input  logic [IMM_W-1:0] wr_imm_i,
    output logic             active_o,
    output logic [CTX_W-1:0] ctx_o,
    output ctx_kind_e        kind_o
);
    localparam int OFF_W   = $clog2(SREG_W + 1);
    localparam int POS_W   = $clog2(SREG_W);
    localparam int RUN_MAX = IMM_W - 1;

    logic [SREG_W-1:0] sreg_q, sreg_n;
    logic [OFF_W-1:0]  off_q, off_n;
    logic [CTX_W-1:0]  ctx_q;
    int                run_len;
    int                off_s;
    int                off_sum;

    // Count the schedule bits carried by the immediate.
    always_comb begin
        int tz;
        tz = IMM_W;
        for (int i = IMM_W - 1; i >= 0; i--) begin
            if (wr_imm_i[i]) tz = i;
        end
        run_len = (tz >= RUN_MAX) ? 0 : RUN_MAX - tz;
    end

    // Next schedule and offset: shift first, then append at the new offset.
    always_comb begin
        sreg_n = step_i ? (sreg_q >> 1) : sreg_q;
        off_s  = int'(off_q);
        if (step_i && off_s > 0) off_s = off_s - 1;
        off_sum = off_s;
        if (wr_i) begin
            for (int k = 0; k < RUN_MAX; k++) begin
                if (k < run_len && (off_s + k) < SREG_W) begin
                    sreg_n[POS_W'(off_s + k)] = wr_imm_i[IMM_W-1-k];
                end
            end
            off_sum = off_s + run_len;
        end
        off_n = (off_sum > SREG_W) ? OFF_W'(SREG_W) : OFF_W'(off_sum);
    end

    // State registers for the schedule and fill offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            off_q  <= '0;
        end else begin
            sreg_q <= sreg_n;
            off_q  <= off_n;
        end
    end

    // Stored context, replaced by each setup to this slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctx_q <= '0;
        else if (wr_i) ctx_q <= wr_ctx_i;
    end

    assign active_o = sreg_q[0];
    assign ctx_o    = ctx_q;
    assign kind_o   = kind_of(ctx_q[CTX_W-1 -: 8]);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(off_q) <= SREG_W);  // R8
    AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sreg_q >> off_q) == '0);  // R3
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i) |=> (sreg_q == ($past(sreg_q) >> 1)));  // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !wr_i) |=> $stable(sreg_q));  // R4

endmodule

// File: rtl/ctxprop_merge.sv
// Module: combinational merge. ORs the contexts of active lanes and flags
// a mix of kinds among them. Assumes lane vectors are aligned by index.
module ctxprop_merge
    import ctxprop_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int CTX_W     = 32
) (
    input  logic [NUM_SLOTS-1:0] active_i,
    input  logic [CTX_W-1:0]     ctx_i  [NUM_SLOTS],
    input  ctx_kind_e            kind_i [NUM_SLOTS],
    output logic                 any_o,
    output logic [CTX_W-1:0]     merged_o,
    output logic                 mixed_o
);
    // OR the active contexts and compare each kind with the first active one.
    always_comb begin
        logic      seen;
        ctx_kind_e ref_kind;
        seen     = 1'b0;
        ref_kind = KIND_RM;
        merged_o = '0;
        mixed_o  = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (active_i[s]) begin
                merged_o = merged_o | ctx_i[s];
                if (!seen) begin
                    seen     = 1'b1;
                    ref_kind = kind_i[s];
                end else if (kind_i[s] != ref_kind) begin
                    mixed_o = 1'b1;
                end
            end
        end
        any_o = seen;
    end

endmodule

// File: rtl/ctxprop_unit.sv
// Module: top of the context propagation unit. Routes setup commands to
// one of the slot lanes, merges lane outputs on each step and registers
// the result for one cycle. Assumes slot index 0 addresses no slot.
module ctxprop_unit
    import ctxprop_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int SREG_W    = 40,
    parameter int IMM_W     = 21,
    parameter int CTX_W     = 32,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic [IDX_W-1:0] setup_idx,
    input  logic [CTX_W-1:0] setup_ctx,
    input  logic [IMM_W-1:0] setup_imm,
    input  logic             step,
    output logic             out_valid,
    output logic [CTX_W-1:0] out_ctx,
    output logic             out_illegal
);
    logic [NUM_SLOTS-1:0] lane_active;
    logic [CTX_W-1:0]     lane_ctx  [NUM_SLOTS];
    ctx_kind_e            lane_kind [NUM_SLOTS];
    logic                 m_any;
    logic [CTX_W-1:0]     m_ctx;
    logic                 m_mixed;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        logic wr_sel;
        // Select this lane when the setup index names it (index = lane + 1).
        assign wr_sel = setup_valid && (setup_idx == IDX_W'(g + 1));
        ctxprop_lane #(
            .SREG_W (SREG_W),
            .IMM_W  (IMM_W),
            .CTX_W  (CTX_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (step),
            .wr_i     (wr_sel),
            .wr_ctx_i (setup_ctx),
            .wr_imm_i (setup_imm),
            .active_o (lane_active[g]),
            .ctx_o    (lane_ctx[g]),
            .kind_o   (lane_kind[g])
        );
    end

    ctxprop_merge #(
        .NUM_SLOTS (NUM_SLOTS),
        .CTX_W     (CTX_W)
    ) u_merge (
        .active_i (lane_active),
        .ctx_i    (lane_ctx),
        .kind_i   (lane_kind),
        .any_o    (m_any),
        .merged_o (m_ctx),
        .mixed_o  (m_mixed)
    );

    // Register the merge result for the cycle after each step; zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !step) begin
            out_valid   <= 1'b0;
            out_ctx     <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= m_any;
            out_ctx     <= m_ctx;
            out_illegal <= m_mixed;
        end
    end

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_ctx == '0 && !out_illegal));  // R7
    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(step));  // R4
    AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid);  // R6
    AST_ACTIVE_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $onehot0(lane_active)) |=> !out_illegal);  // R6

endmodule

// File: tb/ctxprop_unit_test.sv
module ctxprop_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [2:0]  setup_idx = '0;
    logic [31:0] setup_ctx = '0;
    logic [20:0] setup_imm = '0;
    logic        step = 1'b0;
    logic        out_valid;
    logic [31:0] out_ctx;
    logic        out_illegal;

    int errors = 0;
    int checks = 0;

    bit          fifo [1:7][$];
    logic [31:0] ctx_m [1:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxprop_unit uut (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_idx(setup_idx),
        .setup_ctx(setup_ctx), .setup_imm(setup_imm), .step(step),
        .out_valid(out_valid), .out_ctx(out_ctx), .out_illegal(out_illegal)
    );

    function automatic int kind_ref(input logic [31:0] c);
        if (c[31:24] == 8'h00) return 0;
        if (c[31:24] == 8'h01) return 1;
        if (c[31:28] >= 4'h1 && c[31:28] <= 4'h3) return 1 + int'(c[31:28]);
        return 9;
    endfunction

    // One clock: model the edge, drive inputs, then compare after the edge.
    task automatic cyc(input bit st, input bit sv, input int idx,
                       input logic [31:0] c, input logic [20:0] imm, input string tag);
        bit          ev = 0, ei = 0;
        logic [31:0] ec = '0;
        int          k0 = -1;
        if (st) begin
            for (int s = 1; s <= 7; s++) begin
                bit b = 0;
                if (fifo[s].size() > 0) b = fifo[s].pop_front();
                if (b) begin
                    ev = 1;
                    ec |= ctx_m[s];
                    if (k0 < 0) k0 = kind_ref(ctx_m[s]);
                    else if (kind_ref(ctx_m[s]) != k0) ei = 1;
                end
            end
        end
        if (sv && idx != 0) begin
            int low = 21;
            ctx_m[idx] = c;
            for (int i = 20; i >= 0; i--) if (imm[i]) low = i;
            for (int k = 0; k < 20 - low; k++)
                if (fifo[idx].size() < 40) fifo[idx].push_back(imm[20-k]);
        end
        step = st; setup_valid = sv; setup_idx = idx[2:0]; setup_ctx = c; setup_imm = imm;
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== ev || out_ctx !== ec || out_illegal !== ei) begin
            errors++;
            $display("FAIL %s: got v=%b ctx=%h ill=%b expected v=%b ctx=%h ill=%b",
                     tag, out_valid, out_ctx, out_illegal, ev, ec, ei);
        end
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, '0, '0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 1; s <= 7; s++) ctx_m[s] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc(0, 0, 0, '0, '0, "R1 reset outputs");
        steps(3, "R1 R7 empty steps");
        // R2: bits 1,0,1 then stop marker at bit 17.
        cyc(0, 1, 1, 32'h0000_00A1, 21'b1011_0000_0000_0000_00000, "R2 setup");
        steps(5, "R2 run order");
        // R2: zero immediate queues nothing; marker at bit 20 also queues nothing.
        cyc(0, 1, 2, 32'h0000_0F00, 21'd0, "R2 zero imm");
        cyc(0, 1, 2, 32'h0000_0F00, 21'h100000, "R2 marker only");
        steps(2, "R2 nothing queued");
        // R3: two appends to slot 2.
        cyc(0, 1, 2, 32'h0000_0033, 21'b1110_0000_0000_0000_00000, "R3 first");
        cyc(0, 1, 2, 32'h0000_0033, 21'b0110_0000_0000_0000_00000, "R3 second");
        steps(7, "R3 appended run");
        // R5: two RM contexts overlap.
        cyc(0, 1, 3, 32'h0000_1200, 21'b1110_0000_0000_0000_00000, "R5 slot3");
        cyc(0, 1, 5, 32'h0000_0034, 21'b1011_0000_0000_0000_00000, "R5 slot5");
        steps(4, "R5 OR merge");
        // R6: RM with setvl, then swizzle with remap.
        cyc(0, 1, 1, 32'h0000_0001, 21'b1100_0000_0000_0000_00000, "R6 rm");
        cyc(0, 1, 4, 32'h0100_0002, 21'b1010_0000_0000_0000_00000, "R6 setvl");
        steps(3, "R6 mixed rm/setvl");
        cyc(0, 1, 6, 32'h1500_0000, 21'b1100_0000_0000_0000_00000, "R6 swz");
        cyc(0, 1, 7, 32'h2700_0000, 21'b0110_0000_0000_0000_00000, "R6 remap");
        cyc(0, 1, 3, 32'h1800_0001, 21'b1100_0000_0000_0000_00000, "R6 swz2");
        steps(4, "R6 swz/remap");
        // R8: three full runs clip at 40.
        for (int r = 0; r < 3; r++) cyc(0, 1, 4, 32'h0000_0400, 21'h1FFFFF, "R8 fill");
        steps(42, "R8 clip");
        // R9: setup and step together.
        cyc(0, 1, 1, 32'h0000_0011, 21'b1010_0000_0000_0000_00000, "R9 pre");
        cyc(1, 1, 1, 32'h0000_0022, 21'b1100_0000_0000_0000_00000, "R9 same cycle");
        steps(4, "R9 after");
        // R10: index 0 ignored.
        cyc(0, 1, 0, 32'hFFFF_FFFF, 21'h1FFFFF, "R10 idx0");
        steps(2, "R10 nothing applied");
        // R11: context replaced while bits pending.
        cyc(0, 1, 2, 32'h0000_0005, 21'b1111_0000_0000_0000_00000, "R11 first");
        steps(1, "R11 old ctx");
        cyc(0, 1, 2, 32'h0000_0050, 21'd1, "R11 rewrite no bits");
        steps(3, "R11 new ctx");
        // Mixed traffic for R2 R3 R4 R5 R6 R9.
        for (int i = 0; i < 400; i++) begin
            bit          st = ($urandom_range(0, 2) != 0);
            bit          sv = ($urandom_range(0, 3) == 0);
            int          ix = $urandom_range(0, 7);
            logic [31:0] c;
            case ($urandom_range(0, 3))
                0: c = {8'h00, 24'($urandom)};
                1: c = {8'h01, 24'($urandom)};
                2: c = {4'h2, 28'($urandom)};
                default: c = {8'h00, 8'h00, 16'($urandom)};
            endcase
            cyc(st, sv, ix, c, 21'($urandom), "R4 mixed traffic");
        end
        cyc(0, 0, 0, '0, '0, "R4 idle end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule